// File: doc/BRIEF.md
# Transmit DMA Byte Reader

This block moves a software-described run of bytes from memory to a serial transmit stream without processor involvement per byte. Software first loads a start byte address and then writes a byte count. The count write itself launches the transfer, so no separate go bit exists. The engine reads one byte at a time over a simple request/valid memory read port. It presents each byte on a ready/valid transmit stream. After each accepted byte it advances the address in place.

The live address stays readable throughout, so software can watch progress. After completion it shows the start address plus the count, wrapping at the top of the address space. The count register is write-only in effect and always reads back as zero. A `busy` output lets the surrounding port logic hold off direct single-byte writes while a transfer owns the transmit stream.

When no transmit sink is attached, a count write only advances the address by the full count. No memory reads are issued and no bytes leave the block.

Top module: `tdma_tx_reader`

## Requirements
- R1: After reset, `busy`, `mem_req` and `tx_valid` are low and the address register reads as zero.
- R2: A write with `cfg_sel`=1 (count) of a nonzero value N while idle and with `sink_present` high raises `busy` on the next cycle. The transfer delivers exactly N bytes on the stream, then `busy` falls.
- R3: Byte k of a transfer (k counted from 0) is the memory byte at start+k. It is fetched by one read with `mem_addr` = start+k, and bytes leave in increasing address order.
- R4: Reading with `rd_sel`=0 returns the live address. This equals start plus the number of bytes accepted so far, and start+N (modulo 2^ADDR_W) once the transfer is done.
- R5: Reading with `rd_sel`=1 (count) always returns zero.
- R6: A count write of zero starts nothing: `busy` stays low, no memory read is issued and the address is unchanged.
- R7: With `sink_present` low, a nonzero count write N adds N to the address on the next cycle (modulo 2^ADDR_W). It raises neither `busy`, `mem_req` nor `tx_valid`.
- R8: A count write while `busy` is high is ignored; the running transfer still delivers exactly its original N bytes.
- R9: An address write (`cfg_sel`=0) while `busy` is high is ignored; the address continues from its running value.
- R10: While `tx_valid` is high and `tx_ready` low, `tx_valid` and `tx_data` hold steady. No memory read is issued until the held byte is accepted.
- R11: Once `mem_req` is raised, it and `mem_addr` hold steady until `mem_valid` returns the byte.
- R12: Whenever `busy` is low, `mem_req` and `tx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 address, 1 count |
| cfg_wdata | input | ADDR_W | Write data; the count uses the low CNT_W bits |
| rd_sel | input | 1 | Read select: 0 address, 1 count |
| rd_data | output | ADDR_W | Read data for the selected register |
| sink_present | input | 1 | High when a transmit sink is attached |
| busy | output | 1 | High while a transfer is running |
| mem_req | output | 1 | Memory byte read request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit sink ready |

## Verification
The bench builds the block with a 12-bit address and an 8-bit count. Transfers that start just below 0xFFF wrap through zero, both with and without a sink, so address wraparound is exercised. Counts stay short enough that many transfers fit in the run. Several ready patterns, from always-ready to every-other-cycle, exercise held bytes under backpressure. Mid-transfer count and address writes are placed on cycles where a transfer is surely running.

// File: rtl/tdma_pkg.sv
package tdma_pkg;

    localparam int BYTE_W = 8;

    localparam logic SEL_ADDR  = 1'b0;
    localparam logic SEL_COUNT = 1'b1;

    typedef enum logic [1:0] {
        TD_IDLE  = 2'd0,
        TD_FETCH = 2'd1,
        TD_SEND  = 2'd2
    } tdma_state_e;

    typedef struct packed {
        logic load_addr;
        logic launch;
        logic skip;
    } tdma_cmd_t;

    function automatic tdma_cmd_t tdma_decode(
        input logic we,
        input logic sel,
        input logic busy,
        input logic count_nz,
        input logic sink
    );
        tdma_cmd_t c;
        c.load_addr = we && (sel == SEL_ADDR) && !busy;
        c.launch    = we && (sel == SEL_COUNT) && !busy && count_nz && sink;
        c.skip      = we && (sel == SEL_COUNT) && !busy && count_nz && !sink;
        return c;
    endfunction

endpackage

// File: rtl/tdma_cmd_dec.sv
module tdma_cmd_dec
    import tdma_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [CNT_W-1:0] count,
    input  logic             busy,
    input  logic             sink_present,
    output tdma_cmd_t        cmd
);

    always_comb begin
        cmd = tdma_decode(cfg_we, cfg_sel, busy, |count, sink_present);
    end

endmodule

// File: rtl/tdma_addr_reg.sv
module tdma_addr_reg
    import tdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  tdma_cmd_t         cmd,
    input  logic [ADDR_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              step,
    output logic [ADDR_W-1:0] addr_q
);

    logic [ADDR_W-1:0] count_ext;

    assign count_ext = ADDR_W'(count);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (cmd.load_addr) begin
            addr_q <= wdata;
        end else if (cmd.skip) begin
            addr_q <= addr_q + count_ext;
        end else if (step) begin
            addr_q <= addr_q + ADDR_W'(1);
        end
    end

endmodule

// File: rtl/tdma_seq.sv
module tdma_seq
    import tdma_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic [CNT_W-1:0] count,
    input  logic             mem_valid,
    input  logic             tx_ready,
    output logic             busy,
    output logic             mem_req,
    output logic             tx_valid,
    output logic             capture,
    output logic             step
);

    tdma_state_e      state_q;
    tdma_state_e      state_d;
    logic [CNT_W-1:0] remain_q;
    logic             last_byte;

    assign busy      = (state_q != TD_IDLE);
    assign mem_req   = (state_q == TD_FETCH);
    assign tx_valid  = (state_q == TD_SEND);
    assign capture   = mem_req && mem_valid;
    assign step      = tx_valid && tx_ready;
    assign last_byte = (remain_q == CNT_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TD_IDLE:  if (launch)  state_d = TD_FETCH;
            TD_FETCH: if (capture) state_d = TD_SEND;
            TD_SEND:  if (step)    state_d = last_byte ? TD_IDLE : TD_FETCH;
            default:               state_d = TD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= TD_IDLE;
            remain_q <= '0;
        end else begin
            state_q <= state_d;
            if (launch && (state_q == TD_IDLE)) begin
                remain_q <= count;
            end else if (step) begin
                remain_q <= remain_q - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/tdma_byte_hold.sv
module tdma_byte_hold
    import tdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [BYTE_W-1:0] data_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (capture) begin
            data_q <= mem_rdata;
        end
    end

endmodule

// File: rtl/tdma_tx_reader.sv
module tdma_tx_reader
    import tdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              rd_sel,
    output logic [ADDR_W-1:0] rd_data,
    input  logic              sink_present,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [7:0]        mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready
);

    logic [CNT_W-1:0]  count;
    tdma_cmd_t         cmd;
    logic [ADDR_W-1:0] addr_q;
    logic              capture;
    logic              step;

    assign count = cfg_wdata[CNT_W-1:0];

    tdma_cmd_dec #(.CNT_W(CNT_W)) dec_i (
        .cfg_we       (cfg_we),
        .cfg_sel      (cfg_sel),
        .count        (count),
        .busy         (busy),
        .sink_present (sink_present),
        .cmd          (cmd)
    );

    tdma_addr_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) addr_i (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .wdata  (cfg_wdata),
        .count  (count),
        .step   (step),
        .addr_q (addr_q)
    );

    tdma_seq #(.CNT_W(CNT_W)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .launch    (cmd.launch),
        .count     (count),
        .mem_valid (mem_valid),
        .tx_ready  (tx_ready),
        .busy      (busy),
        .mem_req   (mem_req),
        .tx_valid  (tx_valid),
        .capture   (capture),
        .step      (step)
    );

    tdma_byte_hold hold_i (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .mem_rdata (mem_rdata),
        .data_q    (tx_data)
    );

    assign mem_addr = addr_q;
    assign rd_data  = (rd_sel == SEL_COUNT) ? '0 : addr_q;

endmodule

// File: rtl/tdma_tx_reader_chk.sv
module tdma_tx_reader_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic              cfg_sel,
    input logic [ADDR_W-1:0] cfg_wdata,
    input logic              rd_sel,
    input logic [ADDR_W-1:0] rd_data,
    input logic              sink_present,
    input logic              busy,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_valid,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              tx_ready,
    input logic [ADDR_W-1:0] addr_q
);

    logic cnt_nz;
    assign cnt_nz = |cfg_wdata[CNT_W-1:0];

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !busy && !mem_req && !tx_valid && addr_q == '0); // R1
    AST_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel && !busy && cnt_nz && sink_present) |=> busy && mem_req); // R2
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> addr_q == $past(addr_q) + ADDR_W'(1)); // R4
    AST_COUNT_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_sel |-> rd_data == '0); // R5
    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel && !busy && !cnt_nz) |=> !busy && $stable(addr_q)); // R6
    AST_NO_SINK_SKIP: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel && !busy && cnt_nz && !sink_present) |=>
        !busy && addr_q == $past(addr_q) + ADDR_W'($past(cfg_wdata[CNT_W-1:0]))); // R7
    AST_ADDR_WRITE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && cfg_we && !cfg_sel && !(tx_valid && tx_ready)) |=> $stable(addr_q)); // R9
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data)); // R10
    AST_NO_READ_WHILE_HELD: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && tx_valid)); // R10
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> mem_req && $stable(mem_addr)); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req && !tx_valid); // R12

endmodule

bind tdma_tx_reader tdma_tx_reader_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .cfg_sel      (cfg_sel),
    .cfg_wdata    (cfg_wdata),
    .rd_sel       (rd_sel),
    .rd_data      (rd_data),
    .sink_present (sink_present),
    .busy         (busy),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_valid    (mem_valid),
    .tx_valid     (tx_valid),
    .tx_data      (tx_data),
    .tx_ready     (tx_ready),
    .addr_q       (addr_q)
);

// File: tb/tdma_tx_reader_tb_top.sv
module tdma_tx_reader_tb_top;

    localparam int AW = 12;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          rd_sel = 1'b0;
    logic [AW-1:0] rd_data;
    logic          sink_present = 1'b1;
    logic          busy;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_valid = 1'b0;
    logic [7:0]    mem_rdata = '0;
    logic          tx_valid;
    logic [7:0]    tx_data;
    logic          tx_ready = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tdma_tx_reader #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
        .sink_present(sink_present), .busy(busy), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
    );

    function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
        return a[7:0] ^ 8'h5A ^ {a[11:8], 4'h3};
    endfunction

    // memory model: one-cycle latency, single-cycle valid pulse
    initial begin
        forever begin
            @(posedge clk);
            mem_valid <= mem_req && !mem_valid;
            mem_rdata <= mem_byte(mem_addr);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic cfg_write(input logic sel, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // inj: 0 none, 1 count write mid-transfer, 2 address write mid-transfer
    task automatic run_xfer(input logic [AW-1:0] a, input int n, input logic [7:0] pat, input int inj);
        int got = 0;
        logic prev_stall = 1'b0;
        logic [7:0] prev_d = '0;
        logic [AW-1:0] endaddr;
        cfg_write(1'b0, a);
        cfg_write(1'b1, AW'(n));
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        for (int cyc = 0; cyc < 5000; cyc++) begin
            if (cyc > 0) @(negedge clk);
            if (cyc == 2 && inj == 1) begin cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 12'd3; end
            if (cyc == 2 && inj == 2) begin cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 12'h777; end
            if (cyc == 3) cfg_we = 1'b0;
            tx_ready = pat[cyc % 8];
            #1;
            if (prev_stall)
                chk(tx_valid && tx_data == prev_d, "R10 held byte", int'(tx_data), int'(prev_d));
            if (tx_valid && tx_ready) begin
                chk(tx_data == mem_byte(a + AW'(got)), "R3 byte order", int'(tx_data), int'(mem_byte(a + AW'(got))));
                chk(rd_data == a + AW'(got), "R4 live address", int'(rd_data), int'(a + AW'(got)));
                got++;
            end
            prev_stall = tx_valid && !tx_ready;
            prev_d = tx_data;
            if (!busy) break;
        end
        tx_ready = 1'b0;
        endaddr = a + AW'(n);
        chk(got == n, inj == 1 ? "R8 count write while busy" : "R2 byte count", got, n);
        chk(rd_data == endaddr, inj == 2 ? "R9 address write while busy" : "R4 final address",
            int'(rd_data), int'(endaddr));
        chk(!mem_req && !tx_valid, "R12 quiet when idle", int'({mem_req, tx_valid}), 0);
        rd_sel = 1'b1; #1;
        chk(rd_data == '0, "R5 count reads zero", int'(rd_data), 0);
        rd_sel = 1'b0;
    endtask

    typedef struct packed {
        logic [AW-1:0] a;
        logic [7:0]    n;
        logic [7:0]    pat;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{a: 12'h100, n: 8'd5,  pat: 8'hFF},
        '{a: 12'h200, n: 8'd1,  pat: 8'hFF},
        '{a: 12'h3F0, n: 8'd7,  pat: 8'h55},
        '{a: 12'hFFE, n: 8'd4,  pat: 8'h81},
        '{a: 12'h040, n: 8'd20, pat: 8'h0F},
        '{a: 12'h7FF, n: 8'd3,  pat: 8'hE0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !mem_req && !tx_valid && rd_data == '0, "R1 reset state",
            int'({busy, mem_req, tx_valid}), 0);
        @(negedge clk);
        rst = 1'b0;

        foreach (VEC[i]) run_xfer(VEC[i].a, int'(VEC[i].n), VEC[i].pat, 0);

        // R6 zero count
        cfg_write(1'b0, 12'h345);
        cfg_write(1'b1, 12'h000);
        chk(!busy && !mem_req, "R6 zero count starts nothing", int'({busy, mem_req}), 0);
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req && rd_data == 12'h345, "R6 zero count address", int'(rd_data), 'h345);

        // R7 no sink, including wrap
        sink_present = 1'b0;
        cfg_write(1'b0, 12'h0F0);
        cfg_write(1'b1, 12'd10);
        chk(rd_data == 12'h0FA, "R7 skip address", int'(rd_data), 'h0FA);
        chk(!busy && !mem_req && !tx_valid, "R7 no activity", int'({busy, mem_req, tx_valid}), 0);
        cfg_write(1'b0, 12'hFFC);
        cfg_write(1'b1, 12'd8);
        chk(rd_data == 12'h004, "R7 skip wraps", int'(rd_data), 'h004);
        repeat (2) @(negedge clk);
        chk(!busy && !mem_req && !tx_valid, "R7 stays idle", int'({busy, mem_req, tx_valid}), 0);
        sink_present = 1'b1;

        // R8 and R9 writes during a running transfer
        run_xfer(12'h500, 6, 8'h33, 1);
        run_xfer(12'h600, 6, 8'hAA, 2);

        finish_run();
    end

endmodule